// File: doc/BRIEF.md
# Software-Managed Translation Buffer with Zone Override

This block is a small fully associative translation buffer. Privileged software loads, reads back and invalidates its entries through a command port, naming the slot explicitly so that some slots can be kept for pages that must stay resident. The buffer never fetches entries by itself. Each lookup gives a physical address, two storage attribute bits (write-through and inhibit-allocate) and hit, miss, multi-hit and protection-fault flags. These results are registered and appear one cycle after the lookup.

Each entry carries a zone number. A zone override register gives each zone a 2-bit mode. The mode can narrow or widen the entry's read/write/execute rights, so software can change the rights of a whole group of pages without rewriting any entry. When translation is off, the physical address equals the virtual address. In that case the attributes come from a region attribute register, indexed by the top bits of the address, and the access is never faulted.

Top module: `tlb_swmgr_top`

## Requirements
- R1: A privileged command with `cmd_op`=0 writes the entry at `cmd_idx` (valid set). `cmd_op`=1 reads slot `cmd_idx`, and one cycle later `rd_valid` is high with that slot's valid bit and fields on the `rd_*` outputs.
- R2: Any command with `cmd_user`=1, and any command with `cmd_op` above 4, is rejected. `cmd_err` is 1 in the following cycle and no entry or register changes. An accepted command gives `cmd_err`=0.
- R3: With `xlat_en`=1 and exactly one valid entry whose tag equals `lk_vaddr[31:12]`, the result one cycle later has `res_hit`=1, `res_paddr` = {entry page, `lk_vaddr[11:0]`} and `res_attr` = the entry's attribute bits, where bit0 = write-through and bit1 = inhibit-allocate.
- R4: A lookup with no matching valid entry gives `res_miss`=1, `res_hit`=0, `res_fault`=0, `res_paddr`=0 and `res_attr`=0. Command `cmd_op`=2 clears the valid bit of slot `cmd_idx`.
- R5: With `xlat_en`=0, the result has `res_hit`=1, `res_paddr`=`lk_vaddr`, `res_fault`=0 for any access, and `res_attr` = bits [2r+1:2r] of the region register, where r = `lk_vaddr[31:29]`. The region register is written by `cmd_op`=4 from `cmd_data[15:0]`.
- R6: The permission bits are bit0 read, bit1 write, bit2 execute. The access code `lk_acc` is 0 for read, 1 for write, 2 for execute, and 3 is treated as read. When the zone mode is 0, the entry's own rights apply, and a hit whose access is not permitted gives `res_fault`=1.
- R7: Zone z takes its mode from `cmd_data[2z+1:2z]`, written by `cmd_op`=3. Mode 1 denies every access in user mode (`lk_user`=1) and applies the entry's rights in supervisor mode.
- R8: Zone mode 2 permits read, write and execute whatever the entry's rights are.
- R9: Zone mode 3 applies the entry's rights with write removed.
- R10: When two or more valid entries match, the result has `res_multi`=1, `res_miss`=1, `res_hit`=0, `res_fault`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address |
| lk_user | input | 1 | 1 = user mode, 0 = supervisor mode |
| lk_acc | input | 2 | Access type: 0 read, 1 write, 2 execute |
| xlat_en | input | 1 | Translation enable |
| cmd_valid | input | 1 | Management command strobe |
| cmd_user | input | 1 | Privilege of the issuing software (1 = user) |
| cmd_op | input | 3 | 0 write, 1 read, 2 invalidate, 3 zone register, 4 region register |
| cmd_idx | input | 3 | Target slot |
| cmd_tag | input | 20 | Virtual page tag to write |
| cmd_ppn | input | 20 | Physical page to write |
| cmd_zone | input | 4 | Zone number to write |
| cmd_perm | input | 3 | Rights to write {x,w,r} |
| cmd_attr | input | 2 | Attributes to write {inhibit-allocate, write-through} |
| cmd_data | input | 32 | Register data for ops 3 and 4 |
| res_valid | output | 1 | Lookup result valid |
| res_paddr | output | 32 | Physical address |
| res_attr | output | 2 | Storage attributes |
| res_hit | output | 1 | Single-entry hit or translation off |
| res_miss | output | 1 | No usable entry |
| res_multi | output | 1 | More than one entry matched |
| res_fault | output | 1 | Protection fault |
| cmd_err | output | 1 | Command rejected |
| rd_valid | output | 1 | Read-back data valid |
| rd_vld | output | 1 | Read-back valid bit |
| rd_tag | output | 20 | Read-back tag |
| rd_ppn | output | 20 | Read-back physical page |
| rd_zone | output | 4 | Read-back zone |
| rd_perm | output | 3 | Read-back rights |
| rd_attr | output | 2 | Read-back attributes |

## Verification
The bench tries a user-mode entry write and then looks up that page. A design that does not check privilege would hit there instead of missing. A user-mode zone write is followed by an execute that must still fault, which a design accepting that write would not do. The bench steps one zone through all four modes while leaving the entry unchanged. A wrong mode decode shows up as a fault on the wrong access, or as a missing user denial in mode 1. Two entries with the same tag must give a multi-hit miss rather than an OR of the two pages. With translation off, a user write must pass with the region's attributes; a design that still checks rights or uses entry attributes would fault or report the wrong bits.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef enum logic [2:0] {
    OP_WR_ENT  = 3'd0,
    OP_RD_ENT  = 3'd1,
    OP_INV_ENT = 3'd2,
    OP_WR_ZONE = 3'd3,
    OP_WR_RGN  = 3'd4
  } tlb_op_e;

  typedef enum logic [1:0] {
    ACC_RD = 2'd0,
    ACC_WR = 2'd1,
    ACC_EX = 2'd2
  } tlb_acc_e;

  typedef enum logic [1:0] {
    ZM_KEEP     = 2'd0,
    ZM_USR_DENY = 2'd1,
    ZM_FULL     = 2'd2,
    ZM_NO_WR    = 2'd3
  } tlb_zmode_e;
endpackage

// File: rtl/tlb_entry_store.sv
module tlb_entry_store #(
  parameter int N_ENT  = 8,
  parameter int TAG_W  = 20,
  parameter int PPN_W  = 20,
  parameter int ZIDX_W = 4,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              inv_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [PPN_W-1:0]  wr_ppn,
  input  logic [ZIDX_W-1:0] wr_zone,
  input  logic [2:0]        wr_perm,
  input  logic [1:0]        wr_attr,
  input  logic [TAG_W-1:0]  lk_tag,
  output logic [N_ENT-1:0]  hit_vec,
  output logic [PPN_W-1:0]  sel_ppn,
  output logic [ZIDX_W-1:0] sel_zone,
  output logic [2:0]        sel_perm,
  output logic [1:0]        sel_attr,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_vld,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [PPN_W-1:0]  rd_ppn,
  output logic [ZIDX_W-1:0] rd_zone,
  output logic [2:0]        rd_perm,
  output logic [1:0]        rd_attr
);
  typedef struct packed {
    logic              vld;
    logic [TAG_W-1:0]  tag;
    logic [PPN_W-1:0]  ppn;
    logic [ZIDX_W-1:0] zone;
    logic [2:0]        perm;
    logic [1:0]        attr;
  } ent_t;

  ent_t             ent_q [N_ENT];
  ent_t             ent_d [N_ENT];
  logic [N_ENT-1:0] ent_we;

  for (genvar g = 0; g < N_ENT; g++) begin : g_ent
    always_comb begin
      ent_d[g]  = ent_q[g];
      ent_we[g] = (wr_en || inv_en) && (wr_idx == IDX_W'(g));
      if (wr_en) begin
        ent_d[g] = '{vld: 1'b1, tag: wr_tag, ppn: wr_ppn, zone: wr_zone,
                     perm: wr_perm, attr: wr_attr};
      end else begin
        ent_d[g].vld = 1'b0;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          ent_q[g] <= '0;
      else if (ent_we[g])  ent_q[g] <= ent_d[g];
    end

    assign hit_vec[g] = ent_q[g].vld && (ent_q[g].tag == lk_tag);
  end

  // OR-select; meaningful only when a single entry matches
  always_comb begin
    sel_ppn  = '0;
    sel_zone = '0;
    sel_perm = '0;
    sel_attr = '0;
    for (int i = 0; i < N_ENT; i++) begin
      if (hit_vec[i]) begin
        sel_ppn  = sel_ppn  | ent_q[i].ppn;
        sel_zone = sel_zone | ent_q[i].zone;
        sel_perm = sel_perm | ent_q[i].perm;
        sel_attr = sel_attr | ent_q[i].attr;
      end
    end
  end

  assign rd_vld  = ent_q[rd_idx].vld;
  assign rd_tag  = ent_q[rd_idx].tag;
  assign rd_ppn  = ent_q[rd_idx].ppn;
  assign rd_zone = ent_q[rd_idx].zone;
  assign rd_perm = ent_q[rd_idx].perm;
  assign rd_attr = ent_q[rd_idx].attr;

  p_write_lands_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (ent_q[$past(wr_idx)].vld && ent_q[$past(wr_idx)].tag == $past(wr_tag)
               && ent_q[$past(wr_idx)].ppn == $past(wr_ppn)));

  p_inv_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_en && !wr_en) |=> !ent_q[$past(wr_idx)].vld);
endmodule

// File: rtl/tlb_zone_perm.sv
module tlb_zone_perm
  import tlb_pkg::*;
#(
  parameter int ZONES  = 16,
  localparam int ZIDX_W = $clog2(ZONES),
  localparam int ZREG_W = 2 * ZONES
) (
  input  logic [ZREG_W-1:0] zone_reg,
  input  logic [ZIDX_W-1:0] zone_idx,
  input  logic              user,
  input  logic [2:0]        ent_perm,
  input  logic [1:0]        acc,
  output logic              allowed
);
  logic [1:0] mode;
  logic [2:0] eff;

  assign mode = zone_reg[2*zone_idx +: 2];

  always_comb begin
    case (mode)
      ZM_USR_DENY: eff = user ? 3'b000 : ent_perm;
      ZM_FULL:     eff = 3'b111;
      ZM_NO_WR:    eff = ent_perm & 3'b101;
      default:     eff = ent_perm;
    endcase
    case (acc)
      ACC_WR:  allowed = eff[1];
      ACC_EX:  allowed = eff[2];
      default: allowed = eff[0];
    endcase
  end

  always_comb begin
    if (mode == ZM_NO_WR && acc == ACC_WR)
      a_no_write_r9: assert (!allowed);
    if (mode == ZM_USR_DENY && user)
      a_user_deny_r7: assert (!allowed);
  end
endmodule

// File: rtl/tlb_swmgr_top.sv
module tlb_swmgr_top
  import tlb_pkg::*;
#(
  parameter int N_ENT   = 8,
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int OFF_W   = 12,
  parameter int ZONES   = 16,
  parameter int REGIONS = 8,
  localparam int IDX_W  = $clog2(N_ENT),
  localparam int TAG_W  = VA_W - OFF_W,
  localparam int PPN_W  = PA_W - OFF_W,
  localparam int ZIDX_W = $clog2(ZONES),
  localparam int RGN_W  = $clog2(REGIONS),
  localparam int CDAT_W = 2 * ZONES,
  localparam int RREG_W = 2 * REGIONS,
  localparam int CNT_W  = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [VA_W-1:0]   lk_vaddr,
  input  logic              lk_user,
  input  logic [1:0]        lk_acc,
  input  logic              xlat_en,
  input  logic              cmd_valid,
  input  logic              cmd_user,
  input  logic [2:0]        cmd_op,
  input  logic [IDX_W-1:0]  cmd_idx,
  input  logic [TAG_W-1:0]  cmd_tag,
  input  logic [PPN_W-1:0]  cmd_ppn,
  input  logic [ZIDX_W-1:0] cmd_zone,
  input  logic [2:0]        cmd_perm,
  input  logic [1:0]        cmd_attr,
  input  logic [CDAT_W-1:0] cmd_data,
  output logic              res_valid,
  output logic [PA_W-1:0]   res_paddr,
  output logic [1:0]        res_attr,
  output logic              res_hit,
  output logic              res_miss,
  output logic              res_multi,
  output logic              res_fault,
  output logic              cmd_err,
  output logic              rd_valid,
  output logic              rd_vld,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [PPN_W-1:0]  rd_ppn,
  output logic [ZIDX_W-1:0] rd_zone,
  output logic [2:0]        rd_perm,
  output logic [1:0]        rd_attr
);
  // ---------------- command decode ----------------
  logic cmd_ok, cmd_bad, do_wr, do_inv, do_rd, do_zone, do_rgn;
  assign cmd_bad = cmd_valid && (cmd_user || cmd_op > OP_WR_RGN);
  assign cmd_ok  = cmd_valid && !cmd_bad;
  assign do_wr   = cmd_ok && (cmd_op == OP_WR_ENT);
  assign do_rd   = cmd_ok && (cmd_op == OP_RD_ENT);
  assign do_inv  = cmd_ok && (cmd_op == OP_INV_ENT);
  assign do_zone = cmd_ok && (cmd_op == OP_WR_ZONE);
  assign do_rgn  = cmd_ok && (cmd_op == OP_WR_RGN);

  logic [CDAT_W-1:0] zone_q, zone_d;
  logic [RREG_W-1:0] rgn_q, rgn_d;

  always_comb begin
    zone_d = do_zone ? cmd_data : zone_q;
    rgn_d  = do_rgn  ? cmd_data[RREG_W-1:0] : rgn_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      zone_q  <= '0;
      rgn_q   <= '0;
      cmd_err <= 1'b0;
    end else begin
      if (do_zone) zone_q <= zone_d;
      if (do_rgn)  rgn_q  <= rgn_d;
      cmd_err <= cmd_bad;
    end
  end

  // ---------------- entry store ----------------
  logic [N_ENT-1:0]  hit_vec;
  logic [PPN_W-1:0]  sel_ppn, st_ppn;
  logic [ZIDX_W-1:0] sel_zone, st_zone;
  logic [2:0]        sel_perm, st_perm;
  logic [1:0]        sel_attr, st_attr;
  logic [TAG_W-1:0]  st_tag;
  logic              st_vld;

  tlb_entry_store #(.N_ENT(N_ENT), .TAG_W(TAG_W), .PPN_W(PPN_W), .ZIDX_W(ZIDX_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(do_wr), .inv_en(do_inv), .wr_idx(cmd_idx),
    .wr_tag(cmd_tag), .wr_ppn(cmd_ppn), .wr_zone(cmd_zone),
    .wr_perm(cmd_perm), .wr_attr(cmd_attr),
    .lk_tag(lk_vaddr[VA_W-1:OFF_W]),
    .hit_vec(hit_vec), .sel_ppn(sel_ppn), .sel_zone(sel_zone),
    .sel_perm(sel_perm), .sel_attr(sel_attr),
    .rd_idx(cmd_idx), .rd_vld(st_vld), .rd_tag(st_tag), .rd_ppn(st_ppn),
    .rd_zone(st_zone), .rd_perm(st_perm), .rd_attr(st_attr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_vld   <= 1'b0;
      rd_tag   <= '0;
      rd_ppn   <= '0;
      rd_zone  <= '0;
      rd_perm  <= '0;
      rd_attr  <= '0;
    end else begin
      rd_valid <= do_rd;
      if (do_rd) begin
        rd_vld  <= st_vld;
        rd_tag  <= st_tag;
        rd_ppn  <= st_ppn;
        rd_zone <= st_zone;
        rd_perm <= st_perm;
        rd_attr <= st_attr;
      end
    end
  end

  // ---------------- lookup ----------------
  logic              allowed;
  logic [CNT_W-1:0]  hcnt;
  logic [RGN_W-1:0]  rgn;
  logic [PA_W-1:0]   n_pa;
  logic [1:0]        n_attr;
  logic              n_hit, n_miss, n_multi, n_fault;

  tlb_zone_perm #(.ZONES(ZONES)) u_perm (
    .zone_reg(zone_q), .zone_idx(sel_zone), .user(lk_user),
    .ent_perm(sel_perm), .acc(lk_acc), .allowed(allowed)
  );

  assign rgn = lk_vaddr[VA_W-1 -: RGN_W];

  always_comb begin
    hcnt = '0;
    for (int i = 0; i < N_ENT; i++) hcnt = hcnt + CNT_W'(hit_vec[i]);
    n_pa    = '0;
    n_attr  = '0;
    n_hit   = 1'b0;
    n_miss  = 1'b0;
    n_multi = 1'b0;
    n_fault = 1'b0;
    if (!xlat_en) begin
      n_hit  = 1'b1;
      n_pa   = PA_W'(lk_vaddr);
      n_attr = rgn_q[2*rgn +: 2];
    end else if (hcnt == CNT_W'(1)) begin
      n_hit   = 1'b1;
      n_pa    = {sel_ppn, lk_vaddr[OFF_W-1:0]};
      n_attr  = sel_attr;
      n_fault = !allowed;
    end else begin
      n_miss  = 1'b1;
      n_multi = (hcnt > CNT_W'(1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_paddr <= '0;
      res_attr  <= '0;
      res_hit   <= 1'b0;
      res_miss  <= 1'b0;
      res_multi <= 1'b0;
      res_fault <= 1'b0;
    end else begin
      res_valid <= lk_valid;
      if (lk_valid) begin
        res_paddr <= n_pa;
        res_attr  <= n_attr;
        res_hit   <= n_hit;
        res_miss  <= n_miss;
        res_multi <= n_multi;
        res_fault <= n_fault;
      end
    end
  end

  // ---------------- assertions ----------------
  p_user_cmd_rej_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_user) |=> cmd_err);

  p_zone_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_user) |=> $stable(zone_q) && $stable(rgn_q));

  p_hit_xor_miss_r4: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_hit != res_miss));

  p_fault_on_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_fault) |-> res_hit);

  p_multi_is_miss_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_multi) |-> (res_miss && !res_fault));

  p_xlat_off_ident_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && !xlat_en) |=> (res_hit && !res_fault && res_paddr == PA_W'($past(lk_vaddr))));
endmodule

// File: tb/tlb_swmgr_top_tb.sv
module tlb_swmgr_top_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        lk_valid, lk_user, xlat_en;
  logic [31:0] lk_vaddr;
  logic [1:0]  lk_acc;
  logic        cmd_valid, cmd_user;
  logic [2:0]  cmd_op;
  logic [2:0]  cmd_idx;
  logic [19:0] cmd_tag, cmd_ppn;
  logic [3:0]  cmd_zone;
  logic [2:0]  cmd_perm;
  logic [1:0]  cmd_attr;
  logic [31:0] cmd_data;
  logic        res_valid, res_hit, res_miss, res_multi, res_fault;
  logic [31:0] res_paddr;
  logic [1:0]  res_attr;
  logic        cmd_err, rd_valid, rd_vld;
  logic [19:0] rd_tag, rd_ppn;
  logic [3:0]  rd_zone;
  logic [2:0]  rd_perm;
  logic [1:0]  rd_attr;

  tlb_swmgr_top u_dut (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
    .lk_user(lk_user), .lk_acc(lk_acc), .xlat_en(xlat_en),
    .cmd_valid(cmd_valid), .cmd_user(cmd_user), .cmd_op(cmd_op), .cmd_idx(cmd_idx),
    .cmd_tag(cmd_tag), .cmd_ppn(cmd_ppn), .cmd_zone(cmd_zone), .cmd_perm(cmd_perm),
    .cmd_attr(cmd_attr), .cmd_data(cmd_data),
    .res_valid(res_valid), .res_paddr(res_paddr), .res_attr(res_attr),
    .res_hit(res_hit), .res_miss(res_miss), .res_multi(res_multi), .res_fault(res_fault),
    .cmd_err(cmd_err), .rd_valid(rd_valid), .rd_vld(rd_vld), .rd_tag(rd_tag),
    .rd_ppn(rd_ppn), .rd_zone(rd_zone), .rd_perm(rd_perm), .rd_attr(rd_attr)
  );

  always #10 clk = ~clk;  // 50 MHz

  typedef struct {
    logic [37:0] v;  // {hit,miss,fault,multi,attr,paddr}
    string       req;
  } exp_t;

  exp_t q[$];
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   done  = 0;
  int   cyc   = 0;

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // monitor: pops expected results as the design produces them
  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      if (q.size() == 0) begin
        check("unexpected result", 64'd1, 64'd0);
      end else begin
        exp_t e;
        e = q.pop_front();
        check(e.req, {26'd0, res_hit, res_miss, res_fault, res_multi, res_attr, res_paddr},
              {26'd0, e.v});
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 20000 && !done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic lookup(input logic [31:0] va, input logic usr, input logic [1:0] acc,
                        input logic xen, input logic h, input logic m, input logic f,
                        input logic mu, input logic [1:0] at, input logic [31:0] pa,
                        input string req);
    exp_t e;
    @(negedge clk);
    lk_valid = 1'b1; lk_vaddr = va; lk_user = usr; lk_acc = acc; xlat_en = xen;
    e.v = {h, m, f, mu, at, pa};
    e.req = req;
    q.push_back(e);
    @(negedge clk);
    lk_valid = 1'b0;
  endtask

  task automatic cmd(input logic [2:0] op, input logic usr, input logic [2:0] idx,
                     input logic [19:0] tag, input logic [19:0] ppn, input logic [3:0] zn,
                     input logic [2:0] perm, input logic [1:0] at, input logic [31:0] data,
                     input logic exp_err, input string req);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_user = usr; cmd_idx = idx; cmd_tag = tag;
    cmd_ppn = ppn; cmd_zone = zn; cmd_perm = perm; cmd_attr = at; cmd_data = data;
    @(negedge clk);
    cmd_valid = 1'b0;
    check(req, {63'd0, cmd_err}, {63'd0, exp_err});
  endtask

  initial begin
    rst_n = 1'b0;
    lk_valid = 0; lk_vaddr = 0; lk_user = 0; lk_acc = 0; xlat_en = 1;
    cmd_valid = 0; cmd_user = 0; cmd_op = 0; cmd_idx = 0; cmd_tag = 0; cmd_ppn = 0;
    cmd_zone = 0; cmd_perm = 0; cmd_attr = 0; cmd_data = 0;
    repeat (3) @(negedge clk);
    check("reset R4", {61'd0, res_valid, cmd_err, rd_valid}, 64'd0);
    rst_n = 1'b1;

    // R4: empty buffer misses
    lookup(32'h1234_5678, 0, 2'd0, 1, 0, 1, 0, 0, 2'b00, 32'h0, "R4 miss after reset");

    // R1: write slot 0 (zone 1, rights r/w, write-through) and read it back
    cmd(3'd0, 0, 3'd0, 20'h12345, 20'hABCDE, 4'd1, 3'b011, 2'b01, 32'h0, 0, "R1 write ok");
    cmd(3'd1, 0, 3'd0, 20'h0, 20'h0, 4'd0, 3'b000, 2'b00, 32'h0, 0, "R1 read ok");
    check("R1 readback", {14'd0, rd_valid, rd_vld, rd_tag, rd_ppn, rd_zone, rd_perm, rd_attr},
          {14'd0, 1'b1, 1'b1, 20'h12345, 20'hABCDE, 4'd1, 3'b011, 2'b01});

    // R2: user-mode write rejected, no state change
    cmd(3'd0, 1, 3'd1, 20'h11111, 20'h22222, 4'd0, 3'b111, 2'b00, 32'h0, 1, "R2 user write err");
    lookup(32'h1111_1000, 0, 2'd0, 1, 0, 1, 0, 0, 2'b00, 32'h0, "R2 rejected write left no entry");
    cmd(3'd5, 0, 3'd0, 20'h0, 20'h0, 4'd0, 3'b000, 2'b00, 32'h0, 1, "R2 unknown op err");
    cmd(3'd3, 1, 3'd0, 20'h0, 20'h0, 4'd0, 3'b000, 2'b00, 32'h8, 1, "R2 user zone write err");
    // zone 1 still mode 0: execute on an r/w page faults
    lookup(32'h1234_5000, 1, 2'd2, 1, 1, 0, 1, 0, 2'b01, 32'hABCD_E000, "R2 zone register unchanged");

    // R3 / R6: hits with entry rights
    lookup(32'h1234_5678, 0, 2'd0, 1, 1, 0, 0, 0, 2'b01, 32'hABCD_E678, "R3 hit translate");
    lookup(32'h1234_5ABC, 1, 2'd1, 1, 1, 0, 0, 0, 2'b01, 32'hABCD_EABC, "R6 write permitted");
    cmd(3'd0, 0, 3'd2, 20'h00042, 20'h00007, 4'd2, 3'b101, 2'b10, 32'h0, 0, "R1 write slot 2");
    lookup(32'h0004_2FFC, 1, 2'd2, 1, 1, 0, 0, 0, 2'b10, 32'h0000_7FFC, "R3 second page exec");
    lookup(32'h0004_2FFC, 1, 2'd1, 1, 1, 0, 1, 0, 2'b10, 32'h0000_7FFC, "R6 write fault");
    lookup(32'h0004_2000, 0, 2'd3, 1, 1, 0, 0, 0, 2'b10, 32'h0000_7000, "R6 code 3 as read");

    // R7: zone 1 mode 1
    cmd(3'd3, 0, 3'd0, 20'h0, 20'h0, 4'd0, 3'b000, 2'b00, 32'h4, 0, "R7 zone write");
    lookup(32'h1234_5000, 1, 2'd0, 1, 1, 0, 1, 0, 2'b01, 32'hABCD_E000, "R7 user denied");
    lookup(32'h1234_5000, 0, 2'd0, 1, 1, 0, 0, 0, 2'b01, 32'hABCD_E000, "R7 supervisor read");
    lookup(32'h1234_5000, 0, 2'd2, 1, 1, 0, 1, 0, 2'b01, 32'hABCD_E000, "R7 supervisor exec");

    // R8: zone 1 mode 2
    cmd(3'd3, 0, 3'd0, 20'h0, 20'h0, 4'd0, 3'b000, 2'b00, 32'h8, 0, "R8 zone write");
    lookup(32'h1234_5010, 1, 2'd2, 1, 1, 0, 0, 0, 2'b01, 32'hABCD_E010, "R8 full exec");

    // R9: zone 1 mode 3
    cmd(3'd3, 0, 3'd0, 20'h0, 20'h0, 4'd0, 3'b000, 2'b00, 32'hC, 0, "R9 zone write");
    lookup(32'h1234_5020, 0, 2'd1, 1, 1, 0, 1, 0, 2'b01, 32'hABCD_E020, "R9 write denied");
    lookup(32'h1234_5020, 1, 2'd0, 1, 1, 0, 0, 0, 2'b01, 32'hABCD_E020, "R9 read allowed");

    // R5: translation off
    cmd(3'd4, 0, 3'd0, 20'h0, 20'h0, 4'd0, 3'b000, 2'b00, 32'h800, 0, "R5 region write");
    lookup(32'hA000_1234, 1, 2'd1, 0, 1, 0, 0, 0, 2'b10, 32'hA000_1234, "R5 region 5 user write");
    lookup(32'h1234_5020, 1, 2'd1, 0, 1, 0, 0, 0, 2'b00, 32'h1234_5020, "R5 region 0 bypass");

    // R10: duplicate tag
    cmd(3'd0, 0, 3'd3, 20'h12345, 20'h55555, 4'd0, 3'b111, 2'b11, 32'h0, 0, "R10 dup write");
    lookup(32'h1234_5000, 0, 2'd0, 1, 0, 1, 0, 1, 2'b00, 32'h0, "R10 multi hit");

    // R4: invalidate
    cmd(3'd2, 0, 3'd3, 20'h0, 20'h0, 4'd0, 3'b000, 2'b00, 32'h0, 0, "R4 inv slot 3");
    lookup(32'h1234_5004, 0, 2'd0, 1, 1, 0, 0, 0, 2'b01, 32'hABCD_E004, "R4 single hit again");
    cmd(3'd2, 0, 3'd0, 20'h0, 20'h0, 4'd0, 3'b000, 2'b00, 32'h0, 0, "R4 inv slot 0");
    lookup(32'h1234_5004, 0, 2'd0, 1, 0, 1, 0, 0, 2'b00, 32'h0, "R4 miss after invalidate");
    cmd(3'd1, 0, 3'd0, 20'h0, 20'h0, 4'd0, 3'b000, 2'b00, 32'h0, 0, "R1 read invalid");
    check("R4 readback valid clear", {62'd0, rd_valid, rd_vld}, {62'd0, 1'b1, 1'b0});

    repeat (3) @(negedge clk);
    check("R3 all results seen", 64'(q.size()), 64'd0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule